// File: doc/BRIEF.md
# Precise Exception Tracker for an In-Order Five-Stage Pipeline

This block follows every instruction in a five-stage in-order integer pipeline (fetch, decode, execute, memory, writeback) and keeps the fault record that belongs to it. Each stage reports faults on strobes. The tracker ORs the reported faults into an eight-bit cause vector that moves down the pipeline with the instruction and its PC. Faults are acted on only when the instruction reaches writeback. Because of this, exceptions are taken in program order: an older instruction that faults late in the pipeline wins over a younger instruction that faulted earlier in time.

When a marked instruction reaches writeback, the tracker raises a one-cycle trap. It reports one cause bit and the PC of that instruction, and it empties every younger stage in the same cycle. One cycle later it asks fetch to move to a fixed handler address. The tracker does not perform the writes. It gives two permissions, one for the memory-stage store and one for the writeback register-file write, and the surrounding pipeline ANDs these with its own enables. A stall holds the fetch-to-memory records in place and sends an empty slot into writeback.

Top module: `exc_tracker`

## Requirements
- R1: While reset is asserted, trap_o, flush_o, redirect_o, rf_write_ok_o and mem_write_ok_o are 0, cause_o is 0 and exc_pc_o is 0.
- R2: Cause vector bit positions are fixed. Fetch faults are if_fault_i bit0 page, bit1 misaligned and bit2 protection, which map to cause bits 0, 1 and 2. The decode illegal opcode maps to bit 3 and the execute arithmetic fault to bit 4. Memory faults are mem_fault_i bit0 page, bit1 misaligned and bit2 protection, which map to cause bits 5, 6 and 7. Each strobe applies to the instruction in that stage during that cycle.
- R3: When one instruction carries several causes, cause_o is one-hot and holds the lowest-numbered set bit.
- R4: A valid instruction with a nonzero vector in writeback raises trap_o for exactly one cycle. In that cycle exc_pc_o is the PC that instruction was fetched with.
- R5: Exceptions are taken in program order. An older instruction that faults in memory traps, and a younger instruction that faulted in fetch during an earlier cycle never traps.
- R6: rf_write_ok_o is 1 only when writeback holds a valid instruction with an all-zero vector. It is never 1 together with trap_o.
- R7: mem_write_ok_o is 0 when the memory-stage instruction has any cause, including a memory fault strobed in the current cycle. It is also 0 when a trap is being taken.
- R8: In the trap cycle flush_o is 1, and the decode, execute and memory records are cleared, so no younger instruction produces a write permission or a trap afterwards.
- R9: redirect_o is 1 in the cycle after a trap, and redirect_pc_o carries the HANDLER_PC parameter.
- R10: While stall_i is 1, the decode, execute and memory records hold their contents and writeback receives an empty slot. Processing resumes when stall_i returns to 0.
- R11: Fault strobes for a stage that holds no valid instruction are ignored and never cause a trap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| stall_i | input | 1 | Hold the decode, execute and memory records and insert a bubble into writeback |
| if_valid_i | input | 1 | A real instruction is in fetch |
| if_pc_i | input | PC_W | PC of the fetched instruction |
| if_fault_i | input | 3 | Fetch faults: bit0 page, bit1 misaligned, bit2 protection |
| id_illegal_i | input | 1 | Decode found an illegal or undefined opcode |
| ex_arith_i | input | 1 | Execute raised an arithmetic fault |
| mem_fault_i | input | 3 | Memory faults: bit0 page, bit1 misaligned, bit2 protection |
| mem_write_ok_o | output | 1 | Permission for the memory-stage store |
| rf_write_ok_o | output | 1 | Permission for the writeback register-file write |
| trap_o | output | 1 | Exception taken this cycle |
| flush_o | output | 1 | Discard all younger instructions this cycle |
| cause_o | output | 8 | One-hot cause of the trapping instruction |
| exc_pc_o | output | PC_W | PC of the trapping instruction |
| redirect_o | output | 1 | Fetch must move to the handler address |
| redirect_pc_o | output | PC_W | Handler address |

## Verification
On every cycle, assertions check that:
- the trap lasts exactly one cycle and is followed by the redirect;
- the register-file and store permissions never coincide with a trap;
- the reported cause is one-hot;
- a flush empties the decode, execute and memory records;
- a stalled record holds its contents.

Some behaviour only the bench scenarios can show. The bench sweeps all 256 fault masks across one instruction and its two followers to confirm the cause mapping, the priority and the exception PC. Separate scenarios check program-order selection against a younger fetch fault, where stalls insert bubbles, and that strobes in empty stages are ignored.

// File: rtl/exc_pkg.sv
package exc_pkg;
  localparam int NCAUSE = 8;
  localparam int NREC   = 4;   // records: decode, execute, memory, writeback
  localparam int NFLT   = 3;   // fault strobes per memory-access stage

  typedef logic [NCAUSE-1:0] cause_t;

  localparam int C_IF_PAGE  = 0;
  localparam int C_IF_ALIGN = 1;
  localparam int C_IF_PROT  = 2;
  localparam int C_ID_ILL   = 3;
  localparam int C_EX_ARITH = 4;
  localparam int C_MEM_PAGE = 5;
  localparam int C_MEM_ALGN = 6;
  localparam int C_MEM_PROT = 7;
endpackage

// File: rtl/exc_stage_rec.sv
module exc_stage_rec
  import exc_pkg::*;
#(
  parameter int PC_W = 32
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            adv_i,
  input  logic            flush_i,
  input  logic            in_valid_i,
  input  logic [PC_W-1:0] in_pc_i,
  input  cause_t          in_vec_i,
  output logic            valid_o,
  output logic [PC_W-1:0] pc_o,
  output cause_t          vec_o
);
  logic            valid_d;
  logic [PC_W-1:0] pc_d;
  cause_t          vec_d;

  always_comb begin
    valid_d = valid_o;
    pc_d    = pc_o;
    vec_d   = vec_o;
    if (flush_i) begin
      valid_d = 1'b0;
      vec_d   = '0;
    end else if (adv_i) begin
      valid_d = in_valid_i;
      pc_d    = in_pc_i;
      vec_d   = in_valid_i ? in_vec_i : '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_o <= 1'b0;
      pc_o    <= '0;
      vec_o   <= '0;
    end else begin
      valid_o <= valid_d;
      pc_o    <= pc_d;
      vec_o   <= vec_d;
    end
  end

  // R10: a record that neither advances nor flushes keeps its contents
  assert_stall_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (!adv_i && !flush_i) |=> ($stable(vec_o) && $stable(valid_o) && $stable(pc_o)));
endmodule

// File: rtl/exc_cause_pick.sv
module exc_cause_pick
  import exc_pkg::*;
(
  input  logic   rst_n,
  input  cause_t vec_i,
  output cause_t pick_o
);
  // isolate the lowest set bit: oldest stage wins within one instruction
  always_comb begin
    pick_o = vec_i & (~vec_i + cause_t'(1));
  end

  always_comb begin
    if (rst_n) begin
      assert_cause_onehot_R3: assert ($onehot0(pick_o) && ((vec_i == '0) == (pick_o == '0)))
        else $error("cause pick not one-hot");
    end
  end
endmodule

// File: rtl/exc_tracker.sv
module exc_tracker
  import exc_pkg::*;
#(
  parameter int              PC_W       = 32,
  parameter logic [PC_W-1:0] HANDLER_PC = 32'h0000_0100
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            stall_i,
  input  logic            if_valid_i,
  input  logic [PC_W-1:0] if_pc_i,
  input  logic [NFLT-1:0] if_fault_i,
  input  logic            id_illegal_i,
  input  logic            ex_arith_i,
  input  logic [NFLT-1:0] mem_fault_i,
  output logic            mem_write_ok_o,
  output logic            rf_write_ok_o,
  output logic            trap_o,
  output logic            flush_o,
  output cause_t          cause_o,
  output logic [PC_W-1:0] exc_pc_o,
  output logic            redirect_o,
  output logic [PC_W-1:0] redirect_pc_o
);
  localparam int WB  = NREC - 1;
  localparam int MEM = NREC - 2;

  // post[s]: faults detected by stage s (0 fetch, 1 decode, 2 execute, 3 memory)
  cause_t          post [NREC];
  logic            st_v  [NREC];
  logic [PC_W-1:0] st_pc [NREC];
  cause_t          st_vec[NREC];
  logic            src_v [NREC];
  logic [PC_W-1:0] src_pc[NREC];
  cause_t          src_vec[NREC];
  logic            adv   [NREC];
  logic            trap;
  logic            redirect_d;
  cause_t          pick;

  always_comb begin
    post[0] = {{(NCAUSE-NFLT){1'b0}}, if_fault_i};
    post[1] = '0;
    post[1][C_ID_ILL] = id_illegal_i;
    post[2] = '0;
    post[2][C_EX_ARITH] = ex_arith_i;
    post[3] = {mem_fault_i, {(NCAUSE-NFLT){1'b0}}};
  end

  genvar j;
  generate
    for (j = 0; j < NREC; j++) begin : g_rec
      if (j == 0) begin : g_src_if
        always_comb begin
          src_v[j]   = if_valid_i;
          src_pc[j]  = if_pc_i;
          src_vec[j] = if_valid_i ? post[j] : '0;
        end
      end else begin : g_src_rec
        always_comb begin
          src_v[j]   = st_v[j-1];
          src_pc[j]  = st_pc[j-1];
          src_vec[j] = st_vec[j-1] | (st_v[j-1] ? post[j] : '0);
        end
      end

      if (j == WB) begin : g_adv_wb
        // writeback always takes a new slot; a stall hands it a bubble
        assign adv[j] = 1'b1;
        exc_stage_rec #(.PC_W(PC_W)) u_rec (
          .clk(clk), .rst_n(rst_n), .adv_i(adv[j]), .flush_i(trap),
          .in_valid_i(src_v[j] && !stall_i), .in_pc_i(src_pc[j]),
          .in_vec_i(src_vec[j]),
          .valid_o(st_v[j]), .pc_o(st_pc[j]), .vec_o(st_vec[j]));
      end else begin : g_adv_pipe
        assign adv[j] = !stall_i;
        exc_stage_rec #(.PC_W(PC_W)) u_rec (
          .clk(clk), .rst_n(rst_n), .adv_i(adv[j]), .flush_i(trap),
          .in_valid_i(src_v[j]), .in_pc_i(src_pc[j]),
          .in_vec_i(src_vec[j]),
          .valid_o(st_v[j]), .pc_o(st_pc[j]), .vec_o(st_vec[j]));
      end
    end
  endgenerate

  exc_cause_pick u_pick (.rst_n(rst_n), .vec_i(st_vec[WB]), .pick_o(pick));

  always_comb begin
    trap           = st_v[WB] && (st_vec[WB] != '0);
    rf_write_ok_o  = st_v[WB] && (st_vec[WB] == '0);
    mem_write_ok_o = st_v[MEM] && (src_vec[WB] == '0) && !trap;
    trap_o         = trap;
    flush_o        = trap;
    cause_o        = trap ? pick : '0;
    exc_pc_o       = trap ? st_pc[WB] : '0;
    redirect_d     = trap;
    redirect_pc_o  = HANDLER_PC;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) redirect_o <= 1'b0;
    else        redirect_o <= redirect_d;
  end

  assert_trap_single_R4: assert property (@(posedge clk) disable iff (!rst_n)
    trap_o |=> !trap_o);
  assert_redirect_after_trap_R9: assert property (@(posedge clk) disable iff (!rst_n)
    trap_o |=> redirect_o);
  assert_no_rf_on_trap_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !(trap_o && rf_write_ok_o));
  assert_no_store_on_trap_R7: assert property (@(posedge clk) disable iff (!rst_n)
    trap_o |-> !mem_write_ok_o);
  assert_flush_clears_R8: assert property (@(posedge clk) disable iff (!rst_n)
    flush_o |=> (!st_v[0] && !st_v[1] && !st_v[2]));
endmodule

// File: tb/test_exc_tracker.sv
module test_exc_tracker;
  localparam int PC_W = 32;
  localparam logic [PC_W-1:0] HPC = 32'h0000_0100;

  logic            clk = 1'b0;
  logic            rst_n;
  logic            stall_i, if_valid_i, id_illegal_i, ex_arith_i;
  logic [PC_W-1:0] if_pc_i;
  logic [2:0]      if_fault_i, mem_fault_i;
  logic            mem_write_ok_o, rf_write_ok_o, trap_o, flush_o, redirect_o;
  logic [7:0]      cause_o;
  logic [PC_W-1:0] exc_pc_o, redirect_pc_o;

  int total = 0;
  int bad   = 0;
  bit done  = 1'b0;

  always #2.5 clk = ~clk;   // 200 MHz

  exc_tracker #(.PC_W(PC_W), .HANDLER_PC(HPC)) i_exc_tracker (
    .clk(clk), .rst_n(rst_n), .stall_i(stall_i), .if_valid_i(if_valid_i),
    .if_pc_i(if_pc_i), .if_fault_i(if_fault_i), .id_illegal_i(id_illegal_i),
    .ex_arith_i(ex_arith_i), .mem_fault_i(mem_fault_i),
    .mem_write_ok_o(mem_write_ok_o), .rf_write_ok_o(rf_write_ok_o),
    .trap_o(trap_o), .flush_o(flush_o), .cause_o(cause_o), .exc_pc_o(exc_pc_o),
    .redirect_o(redirect_o), .redirect_pc_o(redirect_pc_o));

  task automatic chk(input string req, input logic [63:0] got, input logic [63:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s: got %0h expected %0h at %0t", req, got, exp, $time);
    end
  endtask

  task automatic idle_inputs();
    stall_i = 0; if_valid_i = 0; if_pc_i = '0; if_fault_i = '0;
    id_illegal_i = 0; ex_arith_i = 0; mem_fault_i = '0;
  endtask

  // move to the next cycle: inputs are driven just after the rising edge
  task automatic next_cycle();
    @(posedge clk); #1;
    idle_inputs();
  endtask

  task automatic settle();
    @(negedge clk);
  endtask

  initial begin
    idle_inputs();
    rst_n = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R1 trap", trap_o, 0);
    chk("R1 flush", flush_o, 0);
    chk("R1 redirect", redirect_o, 0);
    chk("R1 rf_ok", rf_write_ok_o, 0);
    chk("R1 mem_ok", mem_write_ok_o, 0);
    chk("R1 cause", cause_o, 0);
    chk("R1 pc", exc_pc_o, 0);
    @(posedge clk); #1;
    rst_n = 1;

    // R2 R3 R4 R6 R7 R8 R9: every fault mask on instruction A, clean followers B and C
    for (int m = 0; m < 256; m++) begin
      logic [7:0]      mk;
      logic [7:0]      low;
      logic [PC_W-1:0] pa;
      logic            f;
      mk  = 8'(m);
      low = mk & (~mk + 8'd1);
      pa  = 32'h1000 + 32'(m) * 16;
      f   = (mk != 0);
      // cycle 0: A fetched
      if_valid_i = 1; if_pc_i = pa; if_fault_i = mk[2:0];
      settle(); next_cycle();
      // cycle 1: B fetched, A in decode
      if_valid_i = 1; if_pc_i = pa + 4; id_illegal_i = mk[3];
      settle(); next_cycle();
      // cycle 2: C fetched, A in execute
      if_valid_i = 1; if_pc_i = pa + 8; ex_arith_i = mk[4];
      settle(); next_cycle();
      // cycle 3: A in memory
      mem_fault_i = mk[7:5];
      settle();
      chk("R7 store permission of A", mem_write_ok_o, !f);
      next_cycle();
      // cycle 4: A in writeback
      settle();
      chk("R4 trap", trap_o, f);
      chk("R2 R3 cause", cause_o, low);
      chk("R4 exc_pc", exc_pc_o, f ? pa : 0);
      chk("R6 rf_ok A", rf_write_ok_o, !f);
      chk("R7 store of B during trap", mem_write_ok_o, !f);
      chk("R8 flush", flush_o, f);
      next_cycle();
      // cycle 5: B in writeback unless flushed
      settle();
      chk("R4 single pulse", trap_o, 0);
      chk("R9 redirect", redirect_o, f);
      chk("R9 handler pc", redirect_pc_o, HPC);
      chk("R8 rf_ok B", rf_write_ok_o, !f);
      next_cycle();
      // cycle 6: C
      settle();
      chk("R8 rf_ok C", rf_write_ok_o, !f);
      chk("R9 redirect drops", redirect_o, 0);
      next_cycle();
      settle(); next_cycle();
    end

    // R5: older memory fault beats a younger fetch fault raised earlier
    if_valid_i = 1; if_pc_i = 32'h2000;
    settle(); next_cycle();
    if_valid_i = 1; if_pc_i = 32'h2004; if_fault_i = 3'b001;
    settle(); next_cycle();
    settle(); next_cycle();
    mem_fault_i = 3'b001;
    settle(); next_cycle();
    settle();
    chk("R5 older trap", trap_o, 1);
    chk("R5 cause mem page", cause_o, 8'h20);
    chk("R5 pc older", exc_pc_o, 32'h2000);
    next_cycle();
    settle();
    chk("R5 younger never traps", trap_o, 0);
    next_cycle();
    settle();
    chk("R5 younger never traps 2", trap_o, 0);
    chk("R5 no rf", rf_write_ok_o, 0);
    next_cycle(); settle(); next_cycle();

    // R10: stall in decode delays the execute fault by two cycles
    if_valid_i = 1; if_pc_i = 32'h3000;
    settle(); next_cycle();
    stall_i = 1;
    settle(); next_cycle();
    stall_i = 1;
    settle(); next_cycle();
    settle(); next_cycle();            // cycle 3: A still in decode
    ex_arith_i = 1;                    // cycle 4: A in execute
    settle();
    chk("R10 no trap while held", trap_o, 0);
    chk("R10 no rf while held", rf_write_ok_o, 0);
    next_cycle();
    settle();
    chk("R10 no trap yet", trap_o, 0);
    next_cycle();
    settle();
    chk("R10 delayed trap", trap_o, 1);
    chk("R10 delayed cause", cause_o, 8'h10);
    chk("R10 delayed pc", exc_pc_o, 32'h3000);
    next_cycle(); settle(); next_cycle();

    // R10: stall with A in memory sends bubbles to writeback
    if_valid_i = 1; if_pc_i = 32'h4000;
    settle(); next_cycle();
    settle(); next_cycle();
    settle(); next_cycle();
    stall_i = 1;                       // cycle 3
    settle();
    chk("R10 store ok held A", mem_write_ok_o, 1);
    next_cycle();
    stall_i = 1;                       // cycle 4
    settle();
    chk("R10 bubble in wb", rf_write_ok_o, 0);
    next_cycle();
    settle();                          // cycle 5: still bubble, A moves next
    chk("R10 bubble in wb 2", rf_write_ok_o, 0);
    next_cycle();
    settle();
    chk("R10 A retires once", rf_write_ok_o, 1);
    next_cycle();
    settle();
    chk("R10 A not repeated", rf_write_ok_o, 0);
    next_cycle();

    // R11: strobes with no instruction anywhere
    for (int c = 0; c < 7; c++) begin
      if_fault_i = 3'b111; id_illegal_i = 1; ex_arith_i = 1; mem_fault_i = 3'b111;
      settle();
      chk("R11 empty trap", trap_o, 0);
      chk("R11 empty rf", rf_write_ok_o, 0);
      chk("R11 empty store", mem_write_ok_o, 0);
      chk("R11 empty redirect", redirect_o, 0);
      next_cycle();
    end

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule